// File: doc/BRIEF.md
# SPI EEPROM Command Controller

This block is the serial slave front end of a small byte-wide nonvolatile store of 256 bytes with 16-byte pages. A host selects it by pulling chip select low, shifts in an 8-bit command and, when the command needs one, an 8-bit byte address. It then either shifts data in or shifts read data out. The array is an on-chip register file, and a parameterised cycle counter stands in for the self-timed programming delay.

The serial pins are sampled through a two-flop synchroniser into the system clock. The block supports SPI modes 0 and 3. Page writes are collected in a 16-byte buffer and applied only when chip select rises after whole bytes have arrived. A status byte reports a busy flag while the write timer runs. An external protection block sees the pending operation, its start address and the status byte. It returns a single allow bit, which the controller obeys when it commits the write.

Top module: `spi_eeprom_ctl`

## Requirements
- R1: The first byte after chip select falls is a command. Only 0x06 (set latch), 0x04 (clear latch), 0x05 (status read), 0x01 (status write), 0x03 (array read) and 0x02 (array write) act. Any other value changes nothing until chip select rises.
- R2: Modes 0 and 3 both work. SI is captured on SCK rising edges, SO changes on SCK falling edges, and every byte travels MSB first.
- R3: `so_oe` equals the inverse of `cs_n` as it stood two clock edges earlier. While it is low the block is idle.
- R4: An array read (0x03, address, then data) returns one byte per 8 clocks starting at the address. The address increments after each byte and wraps from 0xFF to 0x00.
- R5: An array write or status write is accepted only while the write enable latch (status bit 1) is set. 0x06 sets the latch and 0x04 clears it.
- R6: During a page write only address bits 3:0 advance. Data therefore wraps inside the 16-byte page, and a 17th byte overwrites the first location written.
- R7: The array and the status register change only at the rising edge of chip select that ends a write holding at least one whole byte. A chip-select rise that falls inside a byte aborts the whole write.
- R8: After a committed write, status bit 0 reads 1 for exactly WR_CYCLES clocks, starting at the third clock edge after `cs_n` rises.
- R9: While status bit 0 is 1, every command other than 0x05 is ignored. A status read repeats the current status byte for every byte clocked out.
- R10: The write enable latch clears in the same cycle that status bit 0 returns to 0.
- R11: The status byte has bit 7 and bits 4:2 set by 0x01 from the same bit positions of the data byte. Bits 6 and 5 always read 1, bit 1 is the latch, and bit 0 is busy. The same byte drives `prot_status`.
- R12: While a write is pending, `prot_op` is 1 for an array write and 2 for a status write, and `prot_addr` holds the start address. If `wr_allow` is low at commit, nothing is written and no busy time starts.
- R13: After reset every array byte reads 0xFF, the status reads 0x60 and `so_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for `so` (pad tristate control) |
| prot_op | output | 2 | Pending write kind: 0 none, 1 array, 2 status |
| prot_addr | output | ADDR_W | Start address of the pending array write |
| prot_status | output | 8 | Current status byte |
| wr_allow | input | 1 | Permission from the protection block, sampled at commit |

## Verification
The expiry of the write timer and a status byte being loaded for output can land in the same cycle. The busy flag and the write enable latch must then fall together, never one without the other. The bench provokes this by polling the status inside one chip-select window that spans the end of a write. Each returned byte must be either the busy image with the latch set or the ready image with the latch clear, and once ready it must stay ready. A second overlap, a commit edge against a command that is ignored because the block is busy, is judged by the per-clock busy model and by read-back of the untouched address.

// File: rtl/spi_eeprom_ctl.sv
module spi_eeprom_ctl #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  output logic [1:0]        prot_op,
  output logic [ADDR_W-1:0] prot_addr,
  output logic [7:0]        prot_status,
  input  logic              wr_allow
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PROG = 8'h02;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADR, S_RD, S_WR, S_SRD, S_SWR, S_SKIP} st_t;

  logic [2:0] sck_q, cs_q;
  logic [1:0] si_q;
  st_t        st;
  logic [2:0] bcnt;
  logic [6:0] sh;
  logic [ADDR_W-1:0] addr, start;
  logic [PAGE-1:0] mask;
  logic [7:0] obuf;
  logic [7:0] mem [DEPTH];
  logic [7:0] pbuf [PAGE];
  logic       so_r, wel, is_rd, sr_pend;
  logic [3:0] sr_nv, sr_new;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      si_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      cs_q  <= {cs_q[1:0], cs_n};
      si_q  <= {si_q[0], si};
    end

  wire sel       = ~cs_q[1];
  wire cs_fall   = ~cs_q[1] &  cs_q[2];
  wire cs_rise   =  cs_q[1] & ~cs_q[2];
  wire sck_rise  =  sck_q[1] & ~sck_q[2];
  wire sck_fall  = ~sck_q[1] &  sck_q[2];
  wire busy      = cnt != '0;
  wire [7:0] byte_in = {sh, si_q[1]};
  wire byte_done = sel & ~cs_fall & sck_rise & (bcnt == 3'd7);
  wire [ADDR_W-1:0] addr_nx = addr + 1'b1;
  wire [7:0] status = {sr_nv[3], 2'b11, sr_nv[2:0], wel, busy};
  wire at_edge   = bcnt == 3'd0;
  wire do_arr    = cs_rise & (st == S_WR) & at_edge & (|mask) & wr_allow;
  wire do_sr     = cs_rise & sr_pend & at_edge & wr_allow;

  assign so          = so_r;
  assign so_oe       = sel;
  assign prot_status = status;
  assign prot_addr   = start;
  assign prot_op     = {sr_pend, (st == S_WR) & (|mask)};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (do_arr) begin
      for (int i = 0; i < PAGE; i++)
        if (mask[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
    end

  always_ff @(posedge clk)
    if (byte_done && st == S_WR) pbuf[addr[PAGE_W-1:0]] <= byte_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      bcnt    <= '0;
      sh      <= '0;
      addr    <= '0;
      start   <= '0;
      mask    <= '0;
      obuf    <= '0;
      so_r    <= 1'b0;
      wel     <= 1'b0;
      is_rd   <= 1'b0;
      sr_pend <= 1'b0;
      sr_nv   <= '0;
      sr_new  <= '0;
      cnt     <= '0;
    end else begin
      if (do_arr || do_sr) cnt <= CNT_W'(WR_CYCLES);
      else if (busy) cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) wel <= 1'b0;
      if (do_sr) sr_nv <= sr_new;

      if (cs_rise) begin
        st      <= S_IDLE;
        sr_pend <= 1'b0;
      end else if (cs_fall) begin
        st   <= S_CMD;
        bcnt <= '0;
        mask <= '0;
        so_r <= 1'b0;
      end else if (sel) begin
        if (sck_rise) begin
          sh   <= byte_in[6:0];
          bcnt <= bcnt + 3'd1;
        end
        if (byte_done) begin
          case (st)
            S_CMD:
              if (busy && byte_in != OP_RDSR) st <= S_SKIP;
              else begin
                case (byte_in)
                  OP_WREN: begin wel <= 1'b1; st <= S_SKIP; end
                  OP_WRDI: begin wel <= 1'b0; st <= S_SKIP; end
                  OP_RDSR: begin obuf <= status; st <= S_SRD; end
                  OP_WRSR: st <= wel ? S_SWR : S_SKIP;
                  OP_READ: begin is_rd <= 1'b1; st <= S_ADR; end
                  OP_PROG: begin is_rd <= 1'b0; st <= wel ? S_ADR : S_SKIP; end
                  default: st <= S_SKIP;
                endcase
              end
            S_ADR: begin
              addr  <= byte_in[ADDR_W-1:0];
              start <= byte_in[ADDR_W-1:0];
              if (is_rd) obuf <= mem[byte_in[ADDR_W-1:0]];
              st <= is_rd ? S_RD : S_WR;
            end
            S_RD: begin
              addr <= addr_nx;
              obuf <= mem[addr_nx];
            end
            S_WR: begin
              mask[addr[PAGE_W-1:0]] <= 1'b1;
              addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
            end
            S_SRD: obuf <= status;
            S_SWR: begin
              sr_new  <= {byte_in[7], byte_in[4:2]};
              sr_pend <= 1'b1;
              st      <= S_SKIP;
            end
            default: ;
          endcase
        end
        if (sck_fall && (st == S_RD || st == S_SRD)) begin
          so_r <= obuf[7];
          obuf <= {obuf[6:0], 1'b0};
        end
      end
    end
endmodule

// File: rtl/spi_eeprom_ctl_chk.sv
module spi_eeprom_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       so_oe,
  input logic       wr_allow,
  input logic [1:0] prot_op,
  input logic [7:0] prot_status
);
  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_status[0]) |-> $past(prot_op != 2'b00 && wr_allow));

  assert_latch_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_status[0]) |-> !prot_status[1]);

  assert_fixed_ones_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prot_status[6:5] == 2'b11);

  assert_quiet_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prot_status[0] |-> prot_op == 2'b00);

  assert_oe_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(cs_n, 2) == 1'b0);

  assert_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(so_oe) |-> $past(cs_n, 2) == 1'b1);
endmodule

bind spi_eeprom_ctl spi_eeprom_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe),
  .wr_allow(wr_allow), .prot_op(prot_op), .prot_status(prot_status)
);

// File: tb/tb_spi_eeprom_ctl.sv
module tb_spi_eeprom_ctl;
  localparam int WR = 2000;
  localparam int H  = 6;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, si = 0, wr_allow = 1;
  logic so, so_oe;
  logic [1:0] prot_op;
  logic [7:0] prot_addr, prot_status;

  spi_eeprom_ctl #(.ADDR_W(8), .PAGE_W(4), .WR_CYCLES(WR)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
    .prot_op(prot_op), .prot_addr(prot_addr), .prot_status(prot_status), .wr_allow(wr_allow));

  int checks = 0, errors = 0;
  bit mode3 = 0, done = 0;
  bit [7:0] mem_m [256];
  bit wel_m = 0;
  bit [3:0] sr_m = 0;
  bit h1 = 1, h2 = 1, h3 = 1;
  int left = 0, arm_req = 0, arm_seen = 0;

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    h1 <= cs_n; h2 <= h1; h3 <= h2;
    if (!rst_n) left <= 0;
    else if (h2 && !h3 && arm_req != arm_seen) begin left <= WR; arm_seen <= arm_req; end
    else if (left > 0) left <= left - 1;
  end

  always @(negedge clk)
    if (rst_n && !done) begin
      chk("R8 busy flag per clock", int'(prot_status[0]), int'(left != 0));
      chk("R3 so_oe per clock", int'(so_oe), int'(!h2));
    end

  function automatic bit bsy();
    return left != 0 || arm_req != arm_seen;
  endfunction
  function automatic bit [7:0] st_m(input bit b);
    return {sr_m[3], 2'b11, sr_m[2:0], wel_m, b};
  endfunction

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic cs_lo; sck = mode3; tick(2); cs_n = 0; tick(4); endtask
  task automatic cs_hi; tick(H); cs_n = 1; tick(8); endtask

  task automatic xbits(input bit [7:0] tx, input int nb, output bit [7:0] rx);
    rx = 0;
    for (int i = 7; i > 7 - nb; i--) begin
      if (mode3) sck = 0;
      si = tx[i];
      tick(H);
      sck = 1;
      rx[i] = so;
      tick(H);
      if (!mode3) sck = 0;
    end
  endtask
  task automatic xb(input bit [7:0] tx, output bit [7:0] rx); xbits(tx, 8, rx); endtask

  task automatic op_only(input bit [7:0] op);
    bit [7:0] r;
    bit b = bsy();
    cs_lo; xb(op, r); cs_hi;
    if (!b && op == 8'h06) wel_m = 1;
    if (!b && op == 8'h04) wel_m = 0;
  endtask

  task automatic rdsr(input int n, input string tag);
    bit [7:0] r;
    cs_lo; xb(8'h05, r);
    for (int i = 0; i < n; i++) begin xb(8'h00, r); chk(tag, r, st_m(bsy())); end
    cs_hi;
  endtask

  task automatic rd(input bit [7:0] a, input int n, input string tag);
    bit [7:0] r;
    cs_lo; xb(8'h03, r); xb(a, r);
    for (int i = 0; i < n; i++) begin xb(8'h00, r); chk(tag, r, mem_m[8'(a + i)]); end
    cs_hi;
  endtask

  task automatic wr(input bit [7:0] a, input int n, input bit [7:0] first, input int extra, input string tag);
    bit [7:0] r;
    bit ok = wel_m && !bsy();
    bit commit;
    cs_lo; xb(8'h02, r); xb(a, r);
    for (int i = 0; i < n; i++) xb(8'(first + i * 7), r);
    if (extra > 0) xbits(8'hA5, extra, r);
    if (ok && n > 0) begin
      chk({tag, " R12 prot_op"}, prot_op, 1);
      chk({tag, " R12 prot_addr"}, prot_addr, a);
    end else if (bsy()) chk({tag, " R9 no op while busy"}, prot_op, 0);
    commit = ok && n > 0 && extra == 0 && wr_allow;
    if (commit) begin
      for (int i = 0; i < n; i++) mem_m[{a[7:4], 4'(a[3:0] + i)}] = 8'(first + i * 7);
      arm_req++;
    end
    cs_hi;
  endtask

  task automatic wrsr(input bit [7:0] v, input string tag);
    bit [7:0] r;
    bit ok = wel_m && !bsy();
    cs_lo; xb(8'h01, r); xb(v, r);
    chk(tag, prot_op, ok ? 2 : 0);
    if (ok && wr_allow) begin sr_m = {v[7], v[4:2]}; arm_req++; end
    cs_hi;
  endtask

  task automatic wait_done;
    while (bsy()) tick(1);
    wel_m = 0;
    tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [7:0] r, vb, vr;
    bit seen;
    for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
    tick(5); rst_n = 1; tick(5);
    chk("R13 reset status", prot_status, 8'h60);
    chk("R13 reset so_oe", so_oe, 0);
    rdsr(1, "R11 reset status read");
    rd(8'h10, 2, "R13 erased array");

    wr(8'h20, 1, 8'hAA, 0, "R5 no latch");
    rd(8'h20, 1, "R5 write ignored without latch");
    op_only(8'h06); rdsr(1, "R5 latch set");
    op_only(8'h04); rdsr(1, "R5 latch cleared");
    wrsr(8'h9C, "R5 status write needs latch");
    rdsr(1, "R5 status unchanged");

    op_only(8'h06);
    op_only(8'hFF); op_only(8'h00);
    rdsr(1, "R1 unknown opcode no effect");
    rd(8'h20, 1, "R1 array untouched");

    wr(8'h3E, 4, 8'h11, 0, "R6 page wrap");
    rdsr(2, "R9 status read while busy");
    op_only(8'h04);
    wr(8'h50, 2, 8'h77, 0, "R9 write while busy");
    vb = st_m(1); vr = {sr_m[3], 2'b11, sr_m[2:0], 2'b00};
    seen = 0;
    cs_lo; xb(8'h05, r);
    for (int i = 0; i < 40 && !seen; i++) begin
      xb(8'h00, r);
      if (r == vr) begin seen = 1; checks++; end
      else chk("R10 busy image during poll", r, vb);
    end
    xb(8'h00, r); chk("R10 ready stays ready", r, vr);
    cs_hi;
    chk("R10 ready seen in poll", seen, 1);
    wait_done;
    rdsr(1, "R10 latch cleared after write");
    rd(8'h3E, 2, "R6 page bytes before wrap");
    rd(8'h30, 2, "R6 wrapped bytes");
    rd(8'h50, 2, "R9 ignored write");

    op_only(8'h06); wr(8'h00, 2, 8'h05, 0, "R4 prep low"); wait_done;
    op_only(8'h06); wr(8'hFE, 2, 8'h90, 0, "R4 prep high"); wait_done;
    rd(8'hFE, 4, "R4 address wrap");

    op_only(8'h06); wr(8'h70, 1, 8'h5A, 3, "R7 partial abort");
    rd(8'h70, 1, "R7 aborted write leaves array");
    op_only(8'h04);

    op_only(8'h06); wr(8'h80, 17, 8'h20, 0, "R6 overwrite"); wait_done;
    rd(8'h80, 16, "R6 overwrite in page");

    op_only(8'h06);
    wr_allow = 0;
    wr(8'h90, 2, 8'hC1, 0, "R12 denied");
    wr_allow = 1;
    rd(8'h90, 2, "R12 denied write not applied");
    op_only(8'h04);

    op_only(8'h06); wrsr(8'h9C, "R11 status write op"); wait_done;
    rdsr(1, "R11 status fields");
    chk("R11 status value", prot_status, 8'hFC);

    mode3 = 1; sck = 1; tick(4);
    op_only(8'h06); wr(8'hA4, 3, 8'h3C, 0, "R2 mode 3 write"); wait_done;
    rd(8'hA4, 3, "R2 mode 3 read");
    rdsr(1, "R2 mode 3 status");
    mode3 = 0; sck = 0; tick(4);

    for (int p = 0; p < 3; p++) begin
      op_only(8'h06);
      wr(8'(8'hC0 + p * 16 + p), 8, 8'(p * 37 + 1), 0, "R7 read after write");
      wait_done;
      rd(8'(8'hC0 + p * 16), 16, "R7 read after write data");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule